// File: doc/BRIEF.md
# Board System Control Register Bank

A 4 KB window of control and status registers for a development board. Software reaches it through a simple synchronous bus: a 12-bit byte offset, 32-bit write data and a registered 32-bit read response. The bank holds the board identity word, an LED latch, a 16-bit key register, two pairs of set/clear flag registers (one volatile and one kept across reset), a key-guarded reset-control register, a display-control register, a card status word and a free-running tick counter. A few offsets return fixed constants.

The board variant comes from bits 27:16 of the identity parameter. It decides which reset-control bit raises a reset request and whether that register exists at all. It also decides which display bits can be written, whether the 2-bit display mux output is driven, and where write-protect appears in the card status word. Variant codes: 0x100 is the oldest board, 0x140 the second, 0x178 and 0x182 the later pair, 0x190 the newest, and any other code is generic.

Requests are accepted in the cycle `req_valid` is high. There is no back-pressure: the bank is always ready. A read returns data with `rsp_valid` high one clock later.

Top module: `sysreg_bank`

## Requirements
- R1: A write to 0x20 stores exactly 0xA05F when the low 16 bits equal 0xA05F; any other value is stored with bit 15 cleared. A read of 0x20 returns the stored 16 bits.
- R2: The reset-level register at 0x40 takes a write only while the key register holds 0xA05F and only on the oldest and the later variants. On every other variant, 0x40 reads zero.
- R3: An accepted write to 0x40 with bit 8 set on the oldest variant, or with bit 2 set on the later variants, raises `sys_reset_req` for exactly the one cycle after the write.
- R4: A write to 0x30 ORs the data into the flags and a write to 0x34 clears the bits written as 1. 0x30 reads the flags and 0x34 reads zero.
- R5: 0x38 and 0x3C act the same way on the retained flags, which keep their value through `rst`.
- R6: The display register at 0x50 resets to 0x1F00, or to 0 on the newest variant. On the oldest and second variants, bits 13:8 are read-only and the other bits are writable. On the oldest variant, bits 1:0 of each write also drive `disp_mux`. On the later variants, a write keeps the stored bit 7 and takes all other bits from the data. On the newest and generic variants, writes are ignored.
- R7: 0x5C reads a 32-bit counter that is cleared by reset and adds one on each cycle in which `tick_24m` is high.
- R8: 0x00 reads the identity word, 0x08 reads back the LED value that also drives `led_out`, 0x44 reads 1 and 0x88 reads 0xFF000000. Unmapped offsets read zero and ignore writes.
- R9: At 0x48, bit 0 reflects `card_present`. `write_protect` appears at bit 2 on the oldest and second variants and at bit 1 on all others.
- R10: Reset clears the LED, key, flags, reset-level, counter and mux state.
- R11: `rsp_valid` is high exactly one cycle after each accepted read and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| tick_24m | input | 1 | Counter enable strobe at the 24 MHz rate |
| card_present | input | 1 | Card-detect level |
| write_protect | input | 1 | Write-protect level |
| sys_reset_req | output | 1 | One-cycle reset request |
| disp_mux | output | 2 | Display mux select |
| led_out | output | 32 | LED latch value |

## Verification
The assertions assume that a request's fields are stable in the cycle `req_valid` is high, and that `card_present` and `write_protect` are already synchronous to `clk`. The bench changes every input only at the falling edge and holds each request for one full cycle. Three variants (oldest, later and newest) share the same stimulus, so every variant-dependent mask, reset trigger bit and write-protect position is checked side by side.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

  typedef enum logic [2:0] {
    VAR_OLDEST,
    VAR_SECOND,
    VAR_LATE,
    VAR_NEWEST,
    VAR_GENERIC
  } variant_e;

  localparam logic [11:0] OFF_ID       = 12'h000;
  localparam logic [11:0] OFF_LED      = 12'h008;
  localparam logic [11:0] OFF_KEY      = 12'h020;
  localparam logic [11:0] OFF_FLAG_SET = 12'h030;
  localparam logic [11:0] OFF_FLAG_CLR = 12'h034;
  localparam logic [11:0] OFF_NVF_SET  = 12'h038;
  localparam logic [11:0] OFF_NVF_CLR  = 12'h03C;
  localparam logic [11:0] OFF_RSTCTL   = 12'h040;
  localparam logic [11:0] OFF_ONE      = 12'h044;
  localparam logic [11:0] OFF_CARD     = 12'h048;
  localparam logic [11:0] OFF_DISP     = 12'h050;
  localparam logic [11:0] OFF_TICKS    = 12'h05C;
  localparam logic [11:0] OFF_HIGHC    = 12'h088;

  localparam logic [15:0] UNLOCK_KEY = 16'hA05F;

  function automatic variant_e decode_variant(input logic [11:0] board);
    case (board)
      12'h100:          return VAR_OLDEST;
      12'h140:          return VAR_SECOND;
      12'h178, 12'h182: return VAR_LATE;
      12'h190:          return VAR_NEWEST;
      default:          return VAR_GENERIC;
    endcase
  endfunction

endpackage

// File: rtl/sysreg_flagpair.sv
module sysreg_flagpair #(
  parameter int W = 32,
  parameter bit CLEAR_ON_RST = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst && CLEAR_ON_RST)  q <= '0;
    else if (set_we)          q <= q | wdata;
    else if (clr_we)          q <= q & ~wdata;
  end

  a_r4_set_lands: assert property (@(posedge clk) disable iff (rst)
    set_we |=> ((q & $past(wdata)) == $past(wdata)));

  a_r4_clear_lands: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !set_we) |=> ((q & $past(wdata)) == '0));

endmodule

// File: rtl/sysreg_keyreset.sv
module sysreg_keyreset #(
  parameter int W = 32,
  parameter int KEY_W = 16,
  parameter logic [KEY_W-1:0] KEY = 16'hA05F,
  parameter bit HAS_CTL = 1'b1,
  parameter int TRIG_BIT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_we,
  input  logic             ctl_we,
  input  logic [W-1:0]     wdata,
  output logic [KEY_W-1:0] key_q,
  output logic [W-1:0]     level_q,
  output logic             req_o
);

  localparam logic [KEY_W-1:0] TOP_CLR = {1'b0, {(KEY_W-1){1'b1}}};

  logic unlocked;
  logic ctl_ok;

  assign unlocked = (key_q == KEY);
  assign ctl_ok   = HAS_CTL && ctl_we && unlocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q   <= '0;
      level_q <= '0;
      req_o   <= 1'b0;
    end else begin
      if (key_we)
        key_q <= (wdata[KEY_W-1:0] == KEY) ? KEY : (wdata[KEY_W-1:0] & TOP_CLR);
      if (ctl_ok)
        level_q <= wdata;
      req_o <= ctl_ok && wdata[TRIG_BIT];
    end
  end

  a_r1_key_top_clear: assert property (@(posedge clk) disable iff (rst)
    (key_we && wdata[KEY_W-1:0] != KEY) |=> !key_q[KEY_W-1]);

  a_r2_level_frozen: assert property (@(posedge clk) disable iff (rst)
    (key_q != KEY) |=> $stable(level_q));

  a_r3_req_cause: assert property (@(posedge clk) disable iff (rst)
    req_o |-> $past(ctl_we && key_q == KEY && wdata[TRIG_BIT]));

  a_r3_req_single: assert property (@(posedge clk) disable iff (rst)
    (req_o && !ctl_we) |=> !req_o);

endmodule

// File: rtl/sysreg_tickcount.sv
module sysreg_tickcount #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  output logic [W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (tick) count <= count + 1'b1;
  end

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count));

  a_r7_step: assert property (@(posedge clk) disable iff (rst)
    tick |=> (count == W'($past(count) + 1'b1)));

endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
  import sysreg_pkg::*;
#(
  parameter logic [31:0] ID_VALUE = 32'h0100_0000,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int MUX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              tick_24m,
  input  logic              card_present,
  input  logic              write_protect,
  output logic              sys_reset_req,
  output logic [MUX_W-1:0]  disp_mux,
  output logic [DATA_W-1:0] led_out
);

  localparam variant_e VAR = decode_variant(ID_VALUE[27:16]);
  localparam bit HAS_CTL   = (VAR == VAR_OLDEST) || (VAR == VAR_LATE);
  localparam int TRIG_BIT  = (VAR == VAR_OLDEST) ? 8 : 2;
  localparam int WP_BIT    = (VAR == VAR_OLDEST || VAR == VAR_SECOND) ? 2 : 1;
  localparam int KEY_W     = 16;
  localparam logic [DATA_W-1:0] DISP_RST  = (VAR == VAR_NEWEST) ? '0 : DATA_W'(32'h1F00);
  localparam logic [DATA_W-1:0] RO_MASK   = DATA_W'(32'h3F00);
  localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'(32'h0080);

  logic wr, rd;
  assign wr = req_valid &&  req_write;
  assign rd = req_valid && !req_write;

  function automatic logic at(input logic [ADDR_W-1:0] a, input logic [11:0] off);
    return a == ADDR_W'(off);
  endfunction

  logic [DATA_W-1:0] led_q, disp_q, flags_q, nvf_q, level_q, ticks_q;
  logic [KEY_W-1:0]  key_q;
  logic [DATA_W-1:0] card_word, rd_val;

  always_ff @(posedge clk) begin
    if (rst)                      led_q <= '0;
    else if (wr && at(req_addr, OFF_LED)) led_q <= req_wdata;
  end
  assign led_out = led_q;

  sysreg_flagpair #(.W(DATA_W), .CLEAR_ON_RST(1'b1)) u_flags (
    .clk(clk), .rst(rst),
    .set_we(wr && at(req_addr, OFF_FLAG_SET)),
    .clr_we(wr && at(req_addr, OFF_FLAG_CLR)),
    .wdata(req_wdata), .q(flags_q));

  sysreg_flagpair #(.W(DATA_W), .CLEAR_ON_RST(1'b0)) u_nvflags (
    .clk(clk), .rst(rst),
    .set_we(wr && at(req_addr, OFF_NVF_SET)),
    .clr_we(wr && at(req_addr, OFF_NVF_CLR)),
    .wdata(req_wdata), .q(nvf_q));

  sysreg_keyreset #(.W(DATA_W), .KEY_W(KEY_W), .KEY(UNLOCK_KEY),
                    .HAS_CTL(HAS_CTL), .TRIG_BIT(TRIG_BIT)) u_key (
    .clk(clk), .rst(rst),
    .key_we(wr && at(req_addr, OFF_KEY)),
    .ctl_we(wr && at(req_addr, OFF_RSTCTL)),
    .wdata(req_wdata), .key_q(key_q), .level_q(level_q),
    .req_o(sys_reset_req));

  sysreg_tickcount #(.W(DATA_W)) u_ticks (
    .clk(clk), .rst(rst), .tick(tick_24m), .count(ticks_q));

  // Display control register, per-variant write masks
  always_ff @(posedge clk) begin
    if (rst) disp_q <= DISP_RST;
    else if (wr && at(req_addr, OFF_DISP)) begin
      case (VAR)
        VAR_OLDEST, VAR_SECOND: disp_q <= (disp_q & RO_MASK) | (req_wdata & ~RO_MASK);
        VAR_LATE:               disp_q <= (disp_q & KEEP_MASK) | (req_wdata & ~KEEP_MASK);
        default: ;
      endcase
    end
  end

  generate
    if (VAR == VAR_OLDEST) begin : g_mux
      logic [MUX_W-1:0] mux_q;
      always_ff @(posedge clk) begin
        if (rst) mux_q <= '0;
        else if (wr && at(req_addr, OFF_DISP)) mux_q <= req_wdata[MUX_W-1:0];
      end
      assign disp_mux = mux_q;

      a_r6_ro_field: assert property (@(posedge clk) disable iff (rst)
        (wr && at(req_addr, OFF_DISP)) |=> (disp_q[13:8] == $past(disp_q[13:8])));
    end else begin : g_nomux
      assign disp_mux = '0;
    end
  endgenerate

  always_comb begin
    card_word         = '0;
    card_word[0]      = card_present;
    card_word[WP_BIT] = write_protect;
  end

  always_comb begin
    rd_val = '0;
    case (req_addr)
      ADDR_W'(OFF_ID):       rd_val = DATA_W'(ID_VALUE);
      ADDR_W'(OFF_LED):      rd_val = led_q;
      ADDR_W'(OFF_KEY):      rd_val = DATA_W'(key_q);
      ADDR_W'(OFF_FLAG_SET): rd_val = flags_q;
      ADDR_W'(OFF_NVF_SET):  rd_val = nvf_q;
      ADDR_W'(OFF_RSTCTL):   rd_val = HAS_CTL ? level_q : '0;
      ADDR_W'(OFF_ONE):      rd_val = DATA_W'(1);
      ADDR_W'(OFF_CARD):     rd_val = card_word;
      ADDR_W'(OFF_DISP):     rd_val = disp_q;
      ADDR_W'(OFF_TICKS):    rd_val = ticks_q;
      ADDR_W'(OFF_HIGHC):    rd_val = DATA_W'(32'hFF00_0000);
      default:               rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rd_val;
    end
  end

  a_r11_rsp_after_read: assert property (@(posedge clk) disable iff (rst)
    rd |=> rsp_valid);

  a_r11_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
    !rd |=> !rsp_valid);

  a_r9_card_bit: assert property (@(posedge clk) disable iff (rst)
    (rd && at(req_addr, OFF_CARD)) |=> (rsp_rdata[0] == $past(card_present)));

endmodule

// File: tb/sysreg_bank_test.sv
`timescale 1ns/1ps
module sysreg_bank_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        tick_24m = 1'b0, card_present = 1'b0, write_protect = 1'b0;

  logic        v0, v1, v2;
  logic [31:0] d0, d1, d2;
  logic        q0, q1, q2;
  logic [1:0]  m0, m1, m2;
  logic [31:0] l0, l1, l2;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  sysreg_bank #(.ID_VALUE(32'h0100_0000)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(v0), .rsp_rdata(d0),
    .tick_24m(tick_24m), .card_present(card_present), .write_protect(write_protect),
    .sys_reset_req(q0), .disp_mux(m0), .led_out(l0));

  sysreg_bank #(.ID_VALUE(32'h0178_0000)) uut_late (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(v1), .rsp_rdata(d1),
    .tick_24m(tick_24m), .card_present(card_present), .write_protect(write_protect),
    .sys_reset_req(q1), .disp_mux(m1), .led_out(l1));

  sysreg_bank #(.ID_VALUE(32'h0190_0000)) uut_new (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(v2), .rsp_rdata(d2),
    .tick_24m(tick_24m), .card_present(card_present), .write_protect(write_protect),
    .sys_reset_req(q2), .disp_mux(m2), .led_out(l2));

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a,
                          output logic [31:0] r0, output logic [31:0] r1, output logic [31:0] r2);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    r0 = d0; r1 = d1; r2 = d2;
  endtask

  task automatic read3(input string tag, input logic [11:0] a,
                       input logic [31:0] e0, input logic [31:0] e1, input logic [31:0] e2);
    logic [31:0] r0, r1, r2;
    bus_read(a, r0, r1, r2);
    check({tag, " oldest"}, r0, e0);
    check({tag, " later"},  r1, e1);
    check({tag, " newest"}, r2, e2);
  endtask

  function automatic string tag_of(input logic [11:0] a);
    case (a)
      12'h020:          return "R1";
      12'h040:          return "R2";
      12'h030, 12'h034: return "R4";
      12'h050:          return "R6";
      default:          return "R8";
    endcase
  endfunction

  // entry: {is_write, offset, wdata, exp_oldest, exp_later, exp_newest}
  localparam int NV = 26;
  localparam logic [140:0] VEC [0:NV-1] = '{
    {1'b0, 12'h000, 32'h0, 32'h0100_0000, 32'h0178_0000, 32'h0190_0000},
    {1'b0, 12'h044, 32'h0, 32'h1, 32'h1, 32'h1},
    {1'b0, 12'h088, 32'h0, 32'hFF00_0000, 32'hFF00_0000, 32'hFF00_0000},
    {1'b1, 12'h008, 32'hA5, 96'h0},
    {1'b0, 12'h008, 32'h0, 32'hA5, 32'hA5, 32'hA5},
    {1'b1, 12'h020, 32'h1234, 96'h0},
    {1'b0, 12'h020, 32'h0, 32'h1234, 32'h1234, 32'h1234},
    {1'b1, 12'h020, 32'hFFFF, 96'h0},
    {1'b0, 12'h020, 32'h0, 32'h7FFF, 32'h7FFF, 32'h7FFF},
    {1'b1, 12'h040, 32'h55, 96'h0},
    {1'b0, 12'h040, 32'h0, 32'h0, 32'h0, 32'h0},
    {1'b1, 12'h020, 32'hA05F, 96'h0},
    {1'b0, 12'h020, 32'h0, 32'hA05F, 32'hA05F, 32'hA05F},
    {1'b1, 12'h040, 32'h0B, 96'h0},
    {1'b0, 12'h040, 32'h0, 32'h0B, 32'h0B, 32'h0},
    {1'b1, 12'h030, 32'hF0, 96'h0},
    {1'b1, 12'h030, 32'h0F, 96'h0},
    {1'b0, 12'h030, 32'h0, 32'hFF, 32'hFF, 32'hFF},
    {1'b1, 12'h034, 32'h3C, 96'h0},
    {1'b0, 12'h030, 32'h0, 32'hC3, 32'hC3, 32'hC3},
    {1'b0, 12'h034, 32'h0, 32'h0, 32'h0, 32'h0},
    {1'b1, 12'h050, 32'hFFFF_FFFF, 96'h0},
    {1'b0, 12'h050, 32'h0, 32'hFFFF_DFFF, 32'hFFFF_FF7F, 32'h0},
    {1'b1, 12'h060, 32'hDEAD, 96'h0},
    {1'b0, 12'h060, 32'h0, 32'h0, 32'h0, 32'h0},
    {1'b0, 12'h008, 32'h0, 32'hA5, 32'hA5, 32'hA5}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL R11 watchdog got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R10 req after reset", {29'h0, q0, q1, q2}, 32'h0);
    check("R11 no rsp after reset", {29'h0, v0, v1, v2}, 32'h0);
    read3("R10 led", 12'h008, 32'h0, 32'h0, 32'h0);
    read3("R10 flags", 12'h030, 32'h0, 32'h0, 32'h0);
    read3("R10 display", 12'h050, 32'h1F00, 32'h1F00, 32'h0);
    check("R11 rsp one cycle", {31'h0, v0}, 32'h1);
    @(negedge clk);
    check("R11 rsp drops", {31'h0, v0}, 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][140]) bus_write(VEC[i][139:128], VEC[i][127:96]);
      else read3(tag_of(VEC[i][139:128]), VEC[i][139:128],
                 VEC[i][95:64], VEC[i][63:32], VEC[i][31:0]);
    end
    check("R8 led pin", l0, 32'hA5);

    // R6 mux and display masks
    check("R6 mux oldest", {30'h0, m0}, 32'h3);
    check("R6 mux later", {30'h0, m1}, 32'h0);
    bus_write(12'h050, 32'h2);
    check("R6 mux follows", {30'h0, m0}, 32'h2);
    read3("R6 display", 12'h050, 32'h1F02, 32'h2, 32'h0);

    // R3 reset pulse per variant (key is unlocked here)
    bus_write(12'h040, 32'h100);
    check("R3 bit8 oldest", {31'h0, q0}, 32'h1);
    check("R3 bit8 later", {31'h0, q1}, 32'h0);
    check("R3 bit8 newest", {31'h0, q2}, 32'h0);
    @(negedge clk);
    check("R3 one cycle", {31'h0, q0}, 32'h0);
    read3("R2 level", 12'h040, 32'h100, 32'h100, 32'h0);
    bus_write(12'h040, 32'h4);
    check("R3 bit2 oldest", {31'h0, q0}, 32'h0);
    check("R3 bit2 later", {31'h0, q1}, 32'h1);

    // R2 locked again: write ignored, no pulse
    bus_write(12'h020, 32'h0);
    bus_write(12'h040, 32'h104);
    check("R2 locked no pulse", {30'h0, q0, q1}, 32'h0);
    read3("R2 locked level", 12'h040, 32'h4, 32'h4, 32'h0);

    // R9 card status
    card_present = 1'b1; write_protect = 1'b1;
    read3("R9 card+wp", 12'h048, 32'h5, 32'h3, 32'h3);
    card_present = 1'b0;
    read3("R9 wp only", 12'h048, 32'h4, 32'h2, 32'h2);
    write_protect = 1'b0;

    // R5 retained flags
    bus_write(12'h03C, 32'hFFFF_FFFF);
    bus_write(12'h038, 32'hF);
    bus_write(12'h03C, 32'h5);
    read3("R5 retained", 12'h038, 32'hA, 32'hA, 32'hA);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    read3("R5 after reset", 12'h038, 32'hA, 32'hA, 32'hA);
    read3("R10 flags cleared", 12'h030, 32'h0, 32'h0, 32'h0);
    read3("R10 key cleared", 12'h020, 32'h0, 32'h0, 32'h0);
    read3("R10 level cleared", 12'h040, 32'h0, 32'h0, 32'h0);
    read3("R10 display", 12'h050, 32'h1F00, 32'h1F00, 32'h0);
    check("R10 mux", {30'h0, m0}, 32'h0);

    // R7 tick counter
    read3("R7 counter reset", 12'h05C, 32'h0, 32'h0, 32'h0);
    for (int k = 0; k < 7; k++) begin
      @(negedge clk); tick_24m = 1'b1;
      @(negedge clk); tick_24m = 1'b0;
      @(negedge clk);
    end
    read3("R7 gapped", 12'h05C, 32'd7, 32'd7, 32'd7);
    @(negedge clk); tick_24m = 1'b1;
    repeat (5) @(negedge clk);
    tick_24m = 1'b0;
    read3("R7 burst", 12'h05C, 32'd12, 32'd12, 32'd12);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule